// File: doc/BRIEF.md
# Masked Prioritized Interrupt Controller

The controller gathers up to 63 interrupt request lines, numbered 1 to 63, and reports the single most urgent one. Each line has a mask bit and an 8-bit control byte. The control byte holds a 3-bit level and a 3-bit priority. Of these lines, 56 have a level chosen by software. The remaining 7, sources 1 to 7, have a fixed level equal to their own number.

Software reaches all state over a small register bus. Writes take effect at the rising clock edge, and reads are combinational. The outputs are the winning level (0 means no interrupt) and the winner's source number. Both outputs are registered.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Address 64 holds the low mask word (bit i masks source i, for i from 0 to 31). Address 65 holds the high mask word (bit i masks source 32+i). A 1 masks the source and a 0 unmasks it.
- R2: While bit 0 of the low mask word is 1, `irq_level` and `irq_src` are both 0, whatever the other mask bits and requests are. Bit 0 is never a source.
- R3: After reset, both mask words read all ones. Every programmable control byte reads 0. The outputs are 0.
- R4: The control byte of source n sits at address n (n from 1 to 63). Bits [5:3] hold the level and bits [2:0] hold the priority. Bits [7:6] are ignored on write and read as 0.
- R5: A source whose effective level is 0 never wins, whatever its priority.
- R6: Among sources that are requested, unmasked and at a nonzero level, the winner has the highest level. A tie in level goes to the highest priority. Any remaining tie goes to the lowest source number.
- R7: `irq_level` and `irq_src` reflect the request, mask and control state one clock after that state changes.
- R8: Sources 1 to 7 have an effective level equal to their source number. Level bits written to them are ignored, and a read returns that fixed level. Their priority bits are writable.
- R9: When no source qualifies, `irq_level` and `irq_src` are both 0.
- R10: Address 0, and any address above 65, reads 0 and ignores writes. Request line 0 is ignored. Reads of all other addresses return the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 64 | Request lines, active high; bit 0 is unused |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_level | output | 3 | Winning level, 0 = none |
| irq_src | output | 6 | Winning source number, 0 = none |

## Verification
A corrupted mask or control byte changes the winner. That shows on `irq_level` or `irq_src` one clock after the faulty state comes into play, provided the affected source is requested. A fault in a source that is not requested shows only through a register read-back. For that reason the bench mixes random requests with random read-back of every address. Directed cases cover mask-all, ties in level and priority, fixed-level writes and level-0 sources. These make faults in the arbitration order or in a write path show within a few cycles.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC   = 64,
  parameter int NFIXED = 7,
  parameter int LW     = 3,
  parameter int PW     = 3,
  parameter int AW     = 7,
  parameter int DW     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          irq_req,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  output logic [LW-1:0]            irq_level,
  output logic [$clog2(NSRC)-1:0]  irq_src
);
  localparam int SW     = $clog2(NSRC);
  localparam int KW     = LW + PW;
  localparam int NWORDS = NSRC / DW;

  logic [NSRC-1:0] mask_q;
  logic [KW-1:0]   ctrl_q [NSRC];
  logic [KW-1:0]   key_w  [NSRC];
  logic [KW-1:0]   best_key;
  logic [SW-1:0]   best_src;
  logic            mask_all;
  logic            wr_en;
  int              addr_i;

  assign mask_all = mask_q[0];
  assign wr_en    = bus_sel && bus_wr;
  assign addr_i   = int'(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (wr_en) begin
      for (int w = 0; w < NWORDS; w++)
        if (addr_i == NSRC + w) mask_q[w*DW +: DW] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) ctrl_q[i] <= '0;
    end else if (wr_en && addr_i >= 1 && addr_i < NSRC) begin
      ctrl_q[addr_i] <= bus_wdata[KW-1:0];
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_key
    if (g == 0) begin : g_none
      assign key_w[g] = '0;
    end else if (g <= NFIXED) begin : g_fixed
      assign key_w[g] = {LW'(g), ctrl_q[g][PW-1:0]};
    end else begin : g_prog
      assign key_w[g] = ctrl_q[g];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (addr_i >= 1 && addr_i < NSRC) begin
      bus_rdata[KW-1:0] = key_w[addr_i];
    end else begin
      for (int w = 0; w < NWORDS; w++)
        if (addr_i == NSRC + w) bus_rdata = mask_q[w*DW +: DW];
    end
  end

  always_comb begin
    best_key = '0;
    best_src = '0;
    for (int i = NSRC - 1; i >= 1; i--) begin
      if (irq_req[i] && !mask_q[i] && key_w[i][KW-1:PW] != '0 && key_w[i] >= best_key) begin
        best_key = key_w[i];
        best_src = SW'(i);
      end
    end
    if (mask_all) begin
      best_key = '0;
      best_src = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level <= '0;
      irq_src   <= '0;
    end else begin
      irq_level <= best_key[KW-1:PW];
      irq_src   <= best_src;
    end
  end

  p_mask_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all |=> (irq_level == '0 && irq_src == '0));

  p_idle_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) == (irq_src == '0));

  p_winner_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (best_src != '0) |-> (irq_req[best_src] && !mask_q[best_src] && !mask_all));

  p_winner_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (best_src != '0) |-> (key_w[best_src][KW-1:PW] != '0));

  p_registered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (best_src == '0) |=> (irq_src == '0));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_req = '0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_level;
  logic [5:0]  irq_src;

  int checks = 0, fails = 0;
  logic [63:0] mask_m;
  logic [5:0]  ctrl_m [64];

  irq_prio_ctrl uut (.clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_level(irq_level), .irq_src(irq_src));

  always #2.5 clk = ~clk;

  function automatic logic [5:0] eff(int i);
    if (i == 0) return 6'd0;
    if (i <= 7) return {3'(i), ctrl_m[i][2:0]};
    return ctrl_m[i];
  endfunction

  function automatic logic [8:0] winner();
    logic [5:0] bk = 0; int bi = 0;
    if (mask_m[0]) return 9'd0;
    for (int i = 1; i < 64; i++)
      if (irq_req[i] && !mask_m[i] && eff(i)[5:3] != 0 && eff(i) > bk) begin
        bk = eff(i); bi = i;
      end
    return {bk[5:3], 6'(bi)};
  endfunction

  function automatic logic [31:0] rd_model(int a);
    if (a >= 1 && a < 64) return {26'd0, eff(a)};
    if (a == 64) return mask_m[31:0];
    if (a == 65) return mask_m[63:32];
    return 32'd0;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 7'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (a >= 1 && a < 64) ctrl_m[a] = d[5:0];
    else if (a == 64) mask_m[31:0] = d;
    else if (a == 65) mask_m[63:32] = d;
  endtask

  task automatic rd_check(int a, string req);
    bus_addr = 7'(a); bus_sel = 1; bus_wr = 0;
    #1;
    check(bus_rdata == rd_model(a), req, bus_rdata, rd_model(a));
    bus_sel = 0;
  endtask

  task automatic out_check(string req);
    logic [8:0] w;
    repeat (2) @(negedge clk);
    w = winner();
    check({irq_level, irq_src} == w, req, {23'd0, irq_level, irq_src}, {23'd0, w});
  endtask

  initial begin
    #900000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    mask_m = '1;
    for (int i = 0; i < 64; i++) ctrl_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    check(irq_level == 0 && irq_src == 0, "R3", {26'd0, irq_level, irq_src}, 0);
    rd_check(64, "R3"); rd_check(65, "R3"); rd_check(20, "R3"); rd_check(3, "R8");

    // R2 mask-all holds output at zero
    wr(40, 32'h3f); irq_req = 64'hffff_ffff_ffff_fffe;
    wr(65, 32'h0); wr(64, 32'h1);
    out_check("R2");
    wr(64, 32'h0); out_check("R6");
    check(irq_src == 40 && irq_level == 7, "R6", {26'd0, irq_level, irq_src}, {26'd0, 3'd7, 6'd40});
    // R1 mask bit on high word
    wr(65, 32'h0000_0100); out_check("R1");
    check(irq_src != 40, "R1", irq_src, 40);
    // R4 bits 7:6 ignored
    wr(50, 32'hff); rd_check(50, "R4");
    check(bus_rdata == 0 || rd_model(50) == 32'h3f, "R4", rd_model(50), 32'h3f);
    // R6 tie on level and priority: lowest index
    for (int i = 1; i < 64; i++) if (i > 7) wr(i, 0);
    wr(64, 32'h0); wr(65, 32'h0);
    irq_req = '0; irq_req[45] = 1; irq_req[33] = 1;
    wr(45, 32'h2d); wr(33, 32'h2d);
    out_check("R6");
    check(irq_src == 33, "R6", irq_src, 33);
    // R6 level beats priority
    wr(45, 32'h37); wr(33, 32'h2f); out_check("R6");
    // R5 level zero never wins
    irq_req = '0; irq_req[60] = 1; wr(60, 32'h07); out_check("R5");
    check(irq_level == 0 && irq_src == 0, "R9", {26'd0, irq_level, irq_src}, 0);
    // R8 fixed level sources
    irq_req[5] = 1; wr(5, 32'h3a); rd_check(5, "R8"); out_check("R8");
    check(irq_level == 5 && irq_src == 5, "R8", {26'd0, irq_level, irq_src}, {26'd0, 3'd5, 6'd5});
    // R10 address 0 / unmapped, line 0
    wr(0, 32'h3f); rd_check(0, "R10"); wr(100, 32'hffff); rd_check(100, "R10");
    irq_req = 64'h1; out_check("R10");
    // R7 one-cycle update
    irq_req = '0; irq_req[12] = 1; wr(12, 32'h21);
    @(negedge clk); irq_req[12] = 0; irq_req[5] = 1;
    @(negedge clk);
    check(irq_src == 5, "R7", irq_src, 5);

    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 9);
      if (k < 4) wr($urandom_range(0, 63), $urandom);
      else if (k == 4) wr(65, $urandom);
      else if (k == 5) wr(64, $urandom & (($urandom_range(0, 4) == 0) ? 32'hffff_ffff : 32'hffff_fffe));
      else if (k == 6) rd_check($urandom_range(0, 127), "R10");
      else irq_req = {$urandom, $urandom};
      out_check("R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule